// File: doc/BRIEF.md
# Future-Aware Write Cache With Bypass

This block is a small fully associative write cache meant as a hardware yardstick for judging online cache-entrance policies. Every request already carries the logical time at which its address will be requested next, so the cache can apply the clairvoyant rule: on a write miss it removes the entry whose next use is farthest away. It stores no data, only an address and a next-use time per entry.

An optional bypass mode refines the rule. When the cache is full and an incoming write will be needed later than anything already held, the write is not cached at all. Reads never insert. Every request produces a registered response with hit, eviction and bypass flags and the evicted address. Two running counts, write requests and write hits, give the write hit ratio.

Top module: `futureCache`

## Requirements
- R1: After reset every entry is invalid, both counters read zero and rspValid is low.
- R2: Each request accepted on a rising edge produces exactly one response, with rspValid high in the following cycle; rspHit is 1 when the address matches a valid entry.
- R3: A read hit replaces that entry's next-use time with the request's; a read miss changes no entry and never reports an eviction or a bypass.
- R4: A write hit replaces that entry's next-use time with the request's and reports no eviction and no bypass.
- R5: A write miss while an entry is invalid fills the lowest-index invalid entry with the new address and time, with no eviction and no bypass, in either mode.
- R6: A write miss on a full cache with bypassEn low evicts the entry with the largest next-use time, lowest index on a tie, reports rspEvicted=1 with its address on rspEvictAddr, and puts the new pair in its place.
- R7: A write miss on a full cache with bypassEn high and a next-use time strictly greater than every held entry's is not inserted and reports rspBypass=1; if it is equal to or below the largest, R6 applies.
- R8: wrCount rises by one for every write request and wrHitCount by one for every write hit, both visible with the response; reads change neither.
- R9: rspEvicted and rspBypass are never both high, and neither is high on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Logical address of the request |
| reqNext | input | 16 | Logical time of this address's next request |
| bypassEn | input | 1 | Enables the bypass rule on full write misses |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspHit | output | 1 | Request hit a valid entry |
| rspEvicted | output | 1 | An entry was evicted |
| rspEvictAddr | output | 16 | Address of the evicted entry, meaningful when rspEvicted |
| rspBypass | output | 1 | Write miss was declined by the bypass rule |
| wrCount | output | 32 | Number of write requests since reset |
| wrHitCount | output | 32 | Number of write hits since reset |

## Verification
Every result of the block is due exactly one cycle after its request: the response flags, the evicted address and both counters all settle on the same rising edge that samples the request. The driver places a request at a falling edge and queues its expected response; the monitor reads the outputs at the next falling edge, midway between edges, and compares against the head of the queue, so back-to-back requests line up one-for-one. Next-use updates made by hits are observed only through which address a later eviction reports.

// File: rtl/cachePkg.sv
package cachePkg;
  typedef struct packed {
    logic touchHit;   // refresh next-use of the hit entry
    logic fillFree;   // write new pair into lowest invalid entry
    logic evictMax;   // replace entry with farthest next use
    logic bypass;     // decline insertion
    logic countWr;    // bump write counter
    logic countHit;   // bump write-hit counter
  } ctrlStrobes_t;
endpackage

// File: rtl/cacheDatapath.sv
module cacheDatapath
  import cachePkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 16,
  parameter int TIME_W      = 16,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TIME_W-1:0] reqNext,
  input  ctrlStrobes_t      strobes,
  output logic              hit,
  output logic              full,
  output logic              newLater,
  output logic [ADDR_W-1:0] evictAddr,
  output logic [CNT_W-1:0]  wrCount,
  output logic [CNT_W-1:0]  wrHitCount
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] entValid;
  logic [ADDR_W-1:0]      entAddr [NUM_ENTRIES];
  logic [TIME_W-1:0]      entNext [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]       hitIdx;
  logic [IDX_W-1:0]       freeIdx;
  logic [IDX_W-1:0]       maxIdx;
  logic [TIME_W-1:0]      maxNext;

  // Parallel address compare
  generate
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gCmp
      assign hitVec[g] = entValid[g] && (entAddr[g] == reqAddr);
    end
  endgenerate

  assign hit  = |hitVec;
  assign full = &entValid;

  // Lowest-index hit and free slot
  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i])    hitIdx  = IDX_W'(i);
      if (!entValid[i]) freeIdx = IDX_W'(i);
    end
  end

  // Farthest next use, strict compare keeps lowest index on ties
  always_comb begin
    maxIdx  = '0;
    maxNext = entNext[0];
    for (int i = 1; i < NUM_ENTRIES; i++) begin
      if (entNext[i] > maxNext) begin
        maxNext = entNext[i];
        maxIdx  = IDX_W'(i);
      end
    end
  end

  assign newLater = full && (reqNext > maxNext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entValid  <= '0;
      evictAddr <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        entAddr[i] <= '0;
        entNext[i] <= '0;
      end
    end else begin
      if (strobes.touchHit) begin
        entNext[hitIdx] <= reqNext;
      end
      if (strobes.fillFree) begin
        entValid[freeIdx] <= 1'b1;
        entAddr[freeIdx]  <= reqAddr;
        entNext[freeIdx]  <= reqNext;
      end
      if (strobes.evictMax) begin
        evictAddr       <= entAddr[maxIdx];
        entAddr[maxIdx] <= reqAddr;
        entNext[maxIdx] <= reqNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrCount    <= '0;
      wrHitCount <= '0;
    end else begin
      if (strobes.countWr)  wrCount    <= wrCount + CNT_W'(1);
      if (strobes.countHit) wrHitCount <= wrHitCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cacheControl.sv
module cacheControl
  import cachePkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         bypassEn,
  input  logic         hit,
  input  logic         full,
  input  logic         newLater,
  output ctrlStrobes_t strobes,
  output logic         rspValid,
  output logic         rspHit,
  output logic         rspEvicted,
  output logic         rspBypass
);
  logic wrMiss;

  assign wrMiss = reqValid && reqWrite && !hit;

  always_comb begin
    strobes          = '0;
    strobes.touchHit = reqValid && hit;
    strobes.countWr  = reqValid && reqWrite;
    strobes.countHit = reqValid && reqWrite && hit;
    if (wrMiss) begin
      if (!full)                      strobes.fillFree = 1'b1;
      else if (bypassEn && newLater)  strobes.bypass   = 1'b1;
      else                            strobes.evictMax = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspEvicted <= 1'b0;
      rspBypass  <= 1'b0;
    end else begin
      rspValid   <= reqValid;
      rspHit     <= reqValid && hit;
      rspEvicted <= strobes.evictMax;
      rspBypass  <= strobes.bypass;
    end
  end
endmodule

// File: rtl/futureCache.sv
module futureCache
  import cachePkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 16,
  parameter int TIME_W      = 16,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TIME_W-1:0] reqNext,
  input  logic              bypassEn,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspEvicted,
  output logic [ADDR_W-1:0] rspEvictAddr,
  output logic              rspBypass,
  output logic [CNT_W-1:0]  wrCount,
  output logic [CNT_W-1:0]  wrHitCount
);
  ctrlStrobes_t strobes;
  logic hit, full, newLater;

  cacheControl uCtrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqWrite(reqWrite), .bypassEn(bypassEn),
    .hit(hit), .full(full), .newLater(newLater),
    .strobes(strobes),
    .rspValid(rspValid), .rspHit(rspHit),
    .rspEvicted(rspEvicted), .rspBypass(rspBypass)
  );

  cacheDatapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W),
    .TIME_W(TIME_W), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rst_n(rst_n),
    .reqAddr(reqAddr), .reqNext(reqNext),
    .strobes(strobes),
    .hit(hit), .full(full), .newLater(newLater),
    .evictAddr(rspEvictAddr),
    .wrCount(wrCount), .wrHitCount(wrHitCount)
  );
endmodule

// File: rtl/cacheChecker.sv
module cacheChecker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqWrite,
  input logic             rspValid,
  input logic             rspHit,
  input logic             rspEvicted,
  input logic             rspBypass,
  input logic [CNT_W-1:0] wrCount,
  input logic [CNT_W-1:0] wrHitCount
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);

  assert_read_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqWrite) |=> (!rspEvicted && !rspBypass));

  assert_wr_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite) |=> (wrCount == $past(wrCount) + 1'b1));

  assert_read_counts_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && reqWrite) |=> ($stable(wrCount) && $stable(wrHitCount)));

  assert_hits_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrHitCount <= wrCount);

  assert_exclusive_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> $onehot0({rspEvicted, rspBypass, rspHit}));
endmodule

bind futureCache cacheChecker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
  .rspValid(rspValid), .rspHit(rspHit), .rspEvicted(rspEvicted),
  .rspBypass(rspBypass), .wrCount(wrCount), .wrHitCount(wrHitCount)
);

// File: tb/futureCache_test.sv
module futureCache_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, bypassEn = 1'b0;
  logic [15:0] reqAddr = '0, reqNext = '0;
  logic        rspValid, rspHit, rspEvicted, rspBypass;
  logic [15:0] rspEvictAddr;
  logic [31:0] wrCount, wrHitCount;

  int vectors = 0, errors = 0;

  typedef struct {
    logic        hit, evicted, bypass;
    logic [15:0] evAddr;
    logic [31:0] wc, whc;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference state built from the requirements
  logic        mV[N];
  logic [15:0] mA[N], mT[N];
  logic [31:0] mWc = 0, mWhc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  futureCache uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqNext(reqNext), .bypassEn(bypassEn),
    .rspValid(rspValid), .rspHit(rspHit), .rspEvicted(rspEvicted),
    .rspEvictAddr(rspEvictAddr), .rspBypass(rspBypass),
    .wrCount(wrCount), .wrHitCount(wrHitCount)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] t,
                      input logic wr, input logic byp, input string tag);
    expItem_t e;
    int hi, fi, mi;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqNext = t; bypassEn = byp;
    hi = -1; fi = -1; mi = 0;
    for (int i = 0; i < N; i++) begin
      if (hi < 0 && mV[i] && mA[i] == a) hi = i;
      if (fi < 0 && !mV[i]) fi = i;
      if (mT[i] > mT[mi]) mi = i;
    end
    e.hit = (hi >= 0); e.evicted = 0; e.bypass = 0; e.evAddr = '0; e.tag = tag;
    if (wr) mWc++;
    if (hi >= 0) begin
      mT[hi] = t;
      if (wr) mWhc++;
    end else if (wr) begin
      if (fi >= 0) begin
        mV[fi] = 1; mA[fi] = a; mT[fi] = t;
      end else if (byp && t > mT[mi]) begin
        e.bypass = 1;
      end else begin
        e.evicted = 1; e.evAddr = mA[mi]; mA[mi] = a; mT[mi] = t;
      end
    end
    e.wc = mWc; e.whc = mWhc;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compares each response half a cycle after it is registered
  always @(negedge clk) begin
    if (rst_n && rspValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected response", 32'(rspValid), 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check({e.tag, " hit"}, 32'(rspHit), 32'(e.hit));
        check({e.tag, " evicted R9"}, 32'(rspEvicted), 32'(e.evicted));
        check({e.tag, " bypass R9"}, 32'(rspBypass), 32'(e.bypass));
        if (e.evicted) check({e.tag, " evictAddr"}, 32'(rspEvictAddr), 32'(e.evAddr));
        check({e.tag, " wrCount R8"}, wrCount, e.wc);
        check({e.tag, " wrHitCount R8"}, wrHitCount, e.whc);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mV[i] = 0; mA[i] = 0; mT[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rspValid", 32'(rspValid), 0);
    check("R1 wrCount", wrCount, 0);
    check("R1 wrHitCount", wrHitCount, 0);
    // R5: fills, with bypass on the not-full cache still inserts
    send(16'd1, 16'd4, 1, 1, "R5 fill");
    send(16'd2, 16'd5, 1, 0, "R5 fill");
    send(16'd3, 16'd1, 1, 1, "R5 fill");
    send(16'd4, 16'd7, 1, 0, "R5 fill");
    // R3: read hit refreshes, read miss leaves contents
    send(16'd1, 16'd5, 0, 0, "R3 read hit");
    send(16'd5, 16'd8, 0, 0, "R3 read miss");
    // R4: write hit
    send(16'd1, 16'd6, 1, 0, "R4 write hit");
    // R7: bypass declines a later write
    send(16'd5, 16'd8, 1, 1, "R7 bypass");
    // R6: without bypass the farthest (4,7) goes
    send(16'd5, 16'd8, 1, 0, "R6 evict farthest");
    // R6 tie: raise addr 2 to 8 (ties with 5 at index 3), lowest index goes
    send(16'd2, 16'd8, 1, 0, "R4 write hit");
    send(16'd7, 16'd3, 1, 0, "R6 tie lowest index");
    // R7 equal time: not strictly later, so eviction of addr 5
    send(16'd9, 16'd8, 1, 1, "R7 equal evicts");
    // R3: earlier read miss of 5 did not insert; 5 now gone
    send(16'd5, 16'd2, 0, 0, "R3 read after evict");
    idle();
    idle();
    // R2: mixed traffic with gaps
    for (int k = 0; k < 400; k++) begin
      send(16'($urandom_range(0, 9)), 16'($urandom_range(0, 20)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2 random");
      if (k % 7 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    check("R2 all responses seen", 32'(expQ.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule